// File: doc/BRIEF.md
# External Memory Bus Controller with Early Cycle Termination

This block connects one internal requester to an external asynchronous memory bus that carries 16 data lines and 22 byte-address lines, which gives a 4 MB external space. Each request carries an address, a direction and a size: a halfword, a word, or a 16-byte burst. The controller checks the address against a set of programmable chip-select regions. It then runs one 16-bit external beat per halfword. During each beat it drives the matching chip select, the address, and either the read strobe or the write strobe with the write data. It returns a single response once the last beat ends. The bus clock output is the controller clock forwarded to the pins.

A beat normally lasts three bus clocks and ends on an active-low acknowledge input. A device that asserts the acknowledge during the first clock of a beat ends that beat after two clocks. A region can instead select internal termination, where the beat ends after 3 plus the region's wait count clocks even if no acknowledge arrives. Each region has a base, a mask, an enable, a 4-bit wait count and a termination selection.

An address that matches no enabled region gets an error response, and no external cycle is run for it. Only the internal requester can start external transfers.

Top module: `ext_bus_ctrl`

## Requirements
- R1: After reset, all chip selects, the read strobe and the write strobe are high (inactive), data_oe_o is low, req_ready_o is high and rsp_valid_o is low.
- R2: Region g matches when it is enabled and ((addr ^ base_g) & mask_g) is zero, with mask bit 1 meaning the bit is compared. When several regions match, the lowest index wins. During a transfer, exactly the winning chip select cs_n_o[g] is low.
- R3: A request whose address matches no enabled region gets rsp_valid_o with rsp_err_o high on the clock after acceptance. No chip select, read strobe or write strobe goes low for such a request.
- R4: A beat lasts three clocks when ta_n_i is low during its second clock and high during its first.
- R5: A beat lasts two clocks when ta_n_i is low during its first clock. This holds even in a region that uses internal termination.
- R6: In a region with internal termination selected, a beat with no acknowledge lasts 3 plus the region's wait count clocks.
- R7: A word request (req_size_i = 1) runs two beats. The first beat carries bits 31:16 at the request address and the second carries bits 15:0 at the address plus 2.
- R8: A burst request (req_size_i = 2) runs eight beats at addresses that rise by 2 from the request address. Beat k carries bits 127-16k down to 112-16k of the 128-bit data. A halfword request (req_size_i = 0) runs one beat on bits 15:0.
- R9: Read beats hold oe_n_o low and we_n_o high. Write beats hold we_n_o low, oe_n_o high and data_oe_o high, and present the beat's halfword on data_o.
- R10: Each accepted request produces exactly one single-clock rsp_valid_o pulse. Read data is packed so that the first beat lands in the most significant occupied halfword of rsp_rdata_o. req_ready_o stays low while beats are running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller and bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle, request accepted when valid |
| req_addr_i | input | 22 | Byte address, halfword aligned |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | 0 halfword, 1 word, 2 16-byte burst |
| req_wdata_i | input | 128 | Write data, right-aligned to the size |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_err_o | output | 1 | Address matched no enabled region |
| rsp_rdata_o | output | 128 | Read data, right-aligned, first beat most significant |
| cfg_base_i | input | 88 | Region bases, 22 bits each, region g at g*22 |
| cfg_mask_i | input | 88 | Region compare masks |
| cfg_en_i | input | 4 | Region enables |
| cfg_wait_i | input | 16 | Wait counts, 4 bits per region |
| cfg_int_term_i | input | 4 | Internal termination select per region |
| bclk_o | output | 1 | Bus clock output |
| addr_o | output | 22 | External byte address |
| cs_n_o | output | 4 | Active-low chip selects |
| oe_n_o | output | 1 | Active-low read strobe |
| we_n_o | output | 1 | Active-low write strobe |
| data_o | output | 16 | Write data to the bus |
| data_oe_o | output | 1 | Write data driver enable |
| data_i | input | 16 | Read data from the bus |
| ta_n_i | input | 1 | Active-low transfer acknowledge |

## Verification
The bench measures each transfer's length in clocks against a bus model that acknowledges in the first clock, in the second clock, or never. A controller that samples the acknowledge one clock late, or that carries an acknowledge over from the previous beat, would show lengths of three instead of two, or of one. Region tests cover overlapping windows, a disabled window and an unmapped address. A design with the wrong priority would drop the wrong chip select, and one that ignores the enable would run a bus cycle where an error response is due. Word and burst transfers are logged beat by beat to check halfword order and the address step. This catches byte-swapped packing and an address that fails to advance.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  localparam int ADDR_W    = 22;
  localparam int DATA_W    = 16;
  localparam int NCS       = 4;
  localparam int WAIT_W    = 4;
  localparam int MAX_BEATS = 8;

  localparam logic [1:0] SZ_HALF  = 2'd0;
  localparam logic [1:0] SZ_WORD  = 2'd1;
  localparam logic [1:0] SZ_BURST = 2'd2;

  function automatic logic [3:0] beats_of(input logic [1:0] sz);
    case (sz)
      SZ_WORD:  return 4'd2;
      SZ_BURST: return 4'(MAX_BEATS);
      default:  return 4'd1;
    endcase
  endfunction
endpackage

// File: rtl/ebc_cs_decode.sv
module ebc_cs_decode #(
  parameter int NCS    = 4,
  parameter int ADDR_W = 22,
  parameter int WAIT_W = 4
) (
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [NCS*ADDR_W-1:0] base_i,
  input  logic [NCS*ADDR_W-1:0] mask_i,
  input  logic [NCS-1:0]        en_i,
  input  logic [NCS*WAIT_W-1:0] wait_i,
  input  logic [NCS-1:0]        int_term_i,
  output logic                  hit_o,
  output logic [NCS-1:0]        sel_o,
  output logic [WAIT_W-1:0]     wait_o,
  output logic                  int_term_o
);
  logic [NCS-1:0] match;

  for (genvar g = 0; g < NCS; g++) begin : g_region
    assign match[g] = en_i[g] &&
      (((addr_i ^ base_i[g*ADDR_W +: ADDR_W]) & mask_i[g*ADDR_W +: ADDR_W]) == '0);
  end

  // lowest index wins: scan downward so the last match kept is the lowest
  always_comb begin
    hit_o      = 1'b0;
    sel_o      = '0;
    wait_o     = '0;
    int_term_o = 1'b0;
    for (int i = NCS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o      = 1'b1;
        sel_o      = '0;
        sel_o[i]   = 1'b1;
        wait_o     = wait_i[i*WAIT_W +: WAIT_W];
        int_term_o = int_term_i[i];
      end
    end
  end
endmodule

// File: rtl/ebc_beat_timer.sv
module ebc_beat_timer #(
  parameter int WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              active_i,
  input  logic              ta_n_i,
  input  logic              int_term_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic              done_o
);
  localparam int CNT_W = WAIT_W + 2;

  logic [CNT_W-1:0] cnt_q;
  logic             ta_q;   // acknowledge seen low in the previous clock
  logic [CNT_W-1:0] lim;

  assign lim    = CNT_W'(wait_i) + CNT_W'(3);
  assign done_o = active_i && ((cnt_q >= CNT_W'(2) && ta_q) ||
                               (int_term_i && cnt_q == lim));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ta_q  <= 1'b0;
    end else if (start_i || done_o) begin
      cnt_q <= CNT_W'(1);
      ta_q  <= 1'b0;
    end else if (active_i) begin
      if (cnt_q != '1) cnt_q <= cnt_q + CNT_W'(1);
      ta_q <= ~ta_n_i;
    end
  end

  // R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i && int_term_i |-> cnt_q <= lim);
endmodule

// File: rtl/ebc_data_path.sv
module ebc_data_path #(
  parameter int DATA_W    = 16,
  parameter int MAX_BEATS = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  logic [3:0]                    beats_i,
  input  logic [DATA_W*MAX_BEATS-1:0]   wdata_i,
  input  logic                          shift_i,
  input  logic [DATA_W-1:0]             bus_rd_i,
  output logic [DATA_W-1:0]             bus_wr_o,
  output logic [DATA_W*MAX_BEATS-1:0]   rdata_o
);
  localparam int BUF_W = DATA_W * MAX_BEATS;

  logic [BUF_W-1:0] wsh_q;
  logic [BUF_W-1:0] rsh_q;

  assign bus_wr_o = wsh_q[BUF_W-1 -: DATA_W];
  assign rdata_o  = rsh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wsh_q <= '0;
      rsh_q <= '0;
    end else if (load_i) begin
      // move the first beat's halfword to the top of the shifter
      wsh_q <= wdata_i << (DATA_W * (MAX_BEATS - int'(beats_i)));
      rsh_q <= '0;
    end else if (shift_i) begin
      wsh_q <= wsh_q << DATA_W;
      rsh_q <= {rsh_q[BUF_W-DATA_W-1:0], bus_rd_i};
    end
  end
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
  import ebc_pkg::*;
#(
  parameter int ADDR_WIDTH = ADDR_W,
  parameter int DATA_WIDTH = DATA_W,
  parameter int N_CS       = NCS,
  parameter int WAIT_WIDTH = WAIT_W,
  parameter int BEATS_MAX  = MAX_BEATS
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             req_valid_i,
  output logic                             req_ready_o,
  input  logic [ADDR_WIDTH-1:0]            req_addr_i,
  input  logic                             req_we_i,
  input  logic [1:0]                       req_size_i,
  input  logic [DATA_WIDTH*BEATS_MAX-1:0]  req_wdata_i,
  output logic                             rsp_valid_o,
  output logic                             rsp_err_o,
  output logic [DATA_WIDTH*BEATS_MAX-1:0]  rsp_rdata_o,
  input  logic [N_CS*ADDR_WIDTH-1:0]       cfg_base_i,
  input  logic [N_CS*ADDR_WIDTH-1:0]       cfg_mask_i,
  input  logic [N_CS-1:0]                  cfg_en_i,
  input  logic [N_CS*WAIT_WIDTH-1:0]       cfg_wait_i,
  input  logic [N_CS-1:0]                  cfg_int_term_i,
  output logic                             bclk_o,
  output logic [ADDR_WIDTH-1:0]            addr_o,
  output logic [N_CS-1:0]                  cs_n_o,
  output logic                             oe_n_o,
  output logic                             we_n_o,
  output logic [DATA_WIDTH-1:0]            data_o,
  output logic                             data_oe_o,
  input  logic [DATA_WIDTH-1:0]            data_i,
  input  logic                             ta_n_i
);
  logic                  hit;
  logic [N_CS-1:0]       sel;
  logic [WAIT_WIDTH-1:0] wait_d;
  logic                  term_d;
  logic                  accept, start, beat_done;

  logic                  busy_q, we_q, term_q, rsp_valid_q, rsp_err_q;
  logic [ADDR_WIDTH-1:0] addr_q;
  logic [N_CS-1:0]       sel_q;
  logic [WAIT_WIDTH-1:0] wait_q;
  logic [3:0]            beats_left_q;

  ebc_cs_decode #(.NCS(N_CS), .ADDR_W(ADDR_WIDTH), .WAIT_W(WAIT_WIDTH)) u_dec (
    .addr_i(req_addr_i), .base_i(cfg_base_i), .mask_i(cfg_mask_i), .en_i(cfg_en_i),
    .wait_i(cfg_wait_i), .int_term_i(cfg_int_term_i),
    .hit_o(hit), .sel_o(sel), .wait_o(wait_d), .int_term_o(term_d)
  );

  assign accept = req_valid_i && !busy_q;
  assign start  = accept && hit;

  ebc_beat_timer #(.WAIT_W(WAIT_WIDTH)) u_timer (
    .clk_i, .rst_ni, .start_i(start), .active_i(busy_q), .ta_n_i,
    .int_term_i(term_q), .wait_i(wait_q), .done_o(beat_done)
  );

  ebc_data_path #(.DATA_W(DATA_WIDTH), .MAX_BEATS(BEATS_MAX)) u_data (
    .clk_i, .rst_ni, .load_i(start), .beats_i(beats_of(req_size_i)),
    .wdata_i(req_wdata_i), .shift_i(busy_q && beat_done), .bus_rd_i(data_i),
    .bus_wr_o(data_o), .rdata_o(rsp_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q       <= 1'b0;
      we_q         <= 1'b0;
      term_q       <= 1'b0;
      addr_q       <= '0;
      sel_q        <= '0;
      wait_q       <= '0;
      beats_left_q <= '0;
      rsp_valid_q  <= 1'b0;
      rsp_err_q    <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      if (accept) begin
        if (hit) begin
          busy_q       <= 1'b1;
          we_q         <= req_we_i;
          term_q       <= term_d;
          addr_q       <= req_addr_i;
          sel_q        <= sel;
          wait_q       <= wait_d;
          beats_left_q <= beats_of(req_size_i);
        end else begin
          rsp_valid_q <= 1'b1;
          rsp_err_q   <= 1'b1;
        end
      end else if (busy_q && beat_done) begin
        if (beats_left_q == 4'd1) begin
          busy_q      <= 1'b0;
          rsp_valid_q <= 1'b1;
        end else begin
          beats_left_q <= beats_left_q - 4'd1;
          addr_q       <= addr_q + ADDR_WIDTH'(2);
        end
      end
    end
  end

  assign bclk_o      = clk_i;
  assign req_ready_o = !busy_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_err_o   = rsp_err_q;
  assign addr_o      = addr_q;
  assign cs_n_o      = busy_q ? ~sel_q : '1;
  assign oe_n_o      = !(busy_q && !we_q);
  assign we_n_o      = !(busy_q && we_q);
  assign data_oe_o   = busy_q && we_q;

  // R2
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));
  // R9
  no_oe_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!oe_n_o && !we_n_o));
  // R3
  err_no_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_err_o |-> (&cs_n_o) && oe_n_o && we_n_o);
  // R10
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  // R7
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && beat_done && beats_left_q != 4'd1 |=> addr_o == $past(addr_o) + ADDR_WIDTH'(2));
endmodule

// File: tb/ext_bus_ctrl_bench.sv
`timescale 1ns/1ps
module ext_bus_ctrl_bench;
  localparam int AW = 22;
  localparam int DW = 16;
  localparam int NC = 4;
  localparam int BW = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = '0;
  logic [BW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid, rsp_err;
  logic [BW-1:0] rsp_rdata;
  logic [NC*AW-1:0] cfg_base, cfg_mask;
  logic [NC-1:0]    cfg_en, cfg_term;
  logic [NC*4-1:0]  cfg_wait;
  logic          bclk, oe_n, we_n, data_oe;
  logic [AW-1:0] addr;
  logic [NC-1:0] cs_n;
  logic [DW-1:0] dout, din;
  logic          ta_n = 1'b1;

  ext_bus_ctrl u_ext_bus_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_we_i(req_we), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .cfg_base_i(cfg_base), .cfg_mask_i(cfg_mask), .cfg_en_i(cfg_en),
    .cfg_wait_i(cfg_wait), .cfg_int_term_i(cfg_term),
    .bclk_o(bclk), .addr_o(addr), .cs_n_o(cs_n), .oe_n_o(oe_n), .we_n_o(we_n),
    .data_o(dout), .data_oe_o(data_oe), .data_i(din), .ta_n_i(ta_n)
  );

  function automatic logic [15:0] memf(input logic [AW-1:0] a);
    return a[16:1] ^ 16'h5A3C;
  endfunction
  assign din = memf(addr);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // bus model: ack_at 1 = first clock, 2 = second clock, 0 = never
  int ack_at = 2;
  int cyc = 0, nb = 0;
  bit in_beat = 0;
  logic [AW-1:0] prev_addr;
  logic [AW-1:0] b_addr [16];
  logic [NC-1:0] b_cs   [16];
  logic [DW-1:0] b_wd   [16];
  logic          b_rd   [16];
  logic          b_wr   [16];

  always @(negedge clk) begin
    if (cs_n != '1) begin
      if (!in_beat || addr != prev_addr) begin
        cyc = 1;
        if (nb < 16) begin
          b_addr[nb] = addr; b_cs[nb] = cs_n; b_wd[nb] = dout;
          b_rd[nb] = !oe_n && we_n;
          b_wr[nb] = !we_n && oe_n && data_oe;
        end
        nb++;
      end else cyc++;
      in_beat = 1;
      prev_addr = addr;
      ta_n = !(ack_at != 0 && cyc == ack_at);
    end else begin
      in_beat = 0;
      ta_n = 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [AW-1:0] a, input bit we, input logic [1:0] sz,
                      input logic [BW-1:0] wd, input int ack,
                      output int n, output bit err, output logic [BW-1:0] rd,
                      output bit busy_seen_ready);
    @(negedge clk);
    nb = 0; ack_at = ack;
    req_valid = 1'b1; req_addr = a; req_we = we; req_size = sz; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    busy_seen_ready = req_ready;
    n = 0;
    while (!rsp_valid && n < 200) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
    err = rsp_err; rd = rsp_rdata;
    @(negedge clk);
    check(!rsp_valid && req_ready, "R10 single pulse", {126'b0, rsp_valid, req_ready}, 128'h1);
  endtask

  task automatic t_reset();
    check(cs_n == '1 && oe_n && we_n && !data_oe, "R1 strobes idle",
          {cs_n, oe_n, we_n, data_oe}, {4'hf, 3'b110});
    check(req_ready && !rsp_valid, "R1 ready/rsp", {req_ready, rsp_valid}, 2'b10);
  endtask

  task automatic t_half_normal();
    int n; bit e, r; logic [BW-1:0] d;
    xfer(22'h000124, 0, 2'd0, '0, 2, n, e, d, r);
    check(n == 3, "R4 three-clock beat", n, 3);
    check(nb == 1 && b_cs[0] == 4'b1110, "R2 region0 select", b_cs[0], 4'b1110);
    check(b_rd[0], "R9 read strobes", b_rd[0], 1);
    check(!e && d == BW'(memf(22'h000124)), "R8 halfword data", d, memf(22'h000124));
    check(!r, "R10 ready low while busy", r, 0);
  endtask

  task automatic t_half_early();
    int n; bit e, r; logic [BW-1:0] d;
    xfer(22'h000130, 0, 2'd0, '0, 1, n, e, d, r);
    check(n == 2, "R5 early ack two clocks", n, 2);
  endtask

  task automatic t_internal();
    int n; bit e, r; logic [BW-1:0] d;
    xfer(22'h100020, 0, 2'd0, '0, 0, n, e, d, r);
    check(n == 5, "R6 internal term wait 2", n, 5);
    check(b_cs[0] == 4'b1101, "R2 priority over overlapping region3", b_cs[0], 4'b1101);
    xfer(22'h100020, 0, 2'd0, '0, 1, n, e, d, r);
    check(n == 2, "R5 early ack in internal-term region", n, 2);
  endtask

  task automatic t_word_read();
    int n; bit e, r; logic [BW-1:0] d;
    xfer(22'h000200, 0, 2'd1, '0, 2, n, e, d, r);
    check(n == 6 && nb == 2, "R7 word two beats", {n[7:0], nb[7:0]}, {8'd6, 8'd2});
    check(b_addr[0] == 22'h000200 && b_addr[1] == 22'h000202, "R7 address step",
          {b_addr[0], b_addr[1]}, {22'h000200, 22'h000202});
    check(d == BW'({memf(22'h000200), memf(22'h000202)}), "R7 MS halfword first",
          d, {memf(22'h000200), memf(22'h000202)});
  endtask

  task automatic t_word_write();
    int n; bit e, r; logic [BW-1:0] d;
    xfer(22'h000300, 1, 2'd1, BW'(32'hDEADBEEF), 1, n, e, d, r);
    check(n == 4, "R5 word write early ack", n, 4);
    check(b_wd[0] == 16'hDEAD && b_wd[1] == 16'hBEEF, "R7 write halfword order",
          {b_wd[0], b_wd[1]}, 32'hDEADBEEF);
    check(b_wr[0] && b_wr[1], "R9 write strobes", {b_wr[0], b_wr[1]}, 2'b11);
  endtask

  task automatic t_burst_read();
    int n; bit e, r; logic [BW-1:0] d, exp;
    xfer(22'h100010, 0, 2'd2, '0, 0, n, e, d, r);
    check(n == 40 && nb == 8, "R8 burst read eight beats", {n[7:0], nb[7:0]}, {8'd40, 8'd8});
    exp = '0;
    for (int k = 0; k < 8; k++) begin
      exp = {exp[BW-17:0], memf(22'h100010 + 22'(2*k))};
      check(b_addr[k] == 22'h100010 + 22'(2*k), "R8 burst address", b_addr[k],
            22'h100010 + 22'(2*k));
    end
    check(d == exp, "R8 burst packing", d, exp);
  endtask

  task automatic t_burst_write();
    int n; bit e, r; logic [BW-1:0] d, wd;
    wd = 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF;
    xfer(22'h000040, 1, 2'd2, wd, 2, n, e, d, r);
    check(n == 24, "R8 burst write length", n, 24);
    for (int k = 0; k < 8; k++)
      check(b_wd[k] == wd[127-16*k -: 16], "R8 burst write order", b_wd[k], wd[127-16*k -: 16]);
  endtask

  task automatic t_miss();
    int n; bit e, r; logic [BW-1:0] d;
    xfer(22'h200000, 0, 2'd0, '0, 2, n, e, d, r);
    check(n == 0 && e, "R3 disabled region error", {n[7:0], 7'b0, e}, 16'h0001);
    check(nb == 0, "R3 no bus cycle", nb, 0);
    xfer(22'h380000, 1, 2'd1, '0, 2, n, e, d, r);
    check(n == 0 && e && nb == 0, "R3 unmapped error", {n[7:0], nb[7:0], 7'b0, e}, 1);
  endtask

  initial begin
    cfg_base = {22'h100000, 22'h200000, 22'h100000, 22'h000000};
    cfg_mask = {22'h3F0000, 22'h300000, 22'h300000, 22'h3F0000};
    cfg_en   = 4'b1011;
    cfg_wait = {4'd7, 4'd0, 4'd2, 4'd0};
    cfg_term = 4'b1110;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_half_normal();
    t_half_early();
    t_internal();
    t_word_read();
    t_word_write();
    t_burst_read();
    t_burst_write();
    t_miss();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule